// File: doc/BRIEF.md
# MOESI Snooping Line Coherence Controller

This block keeps one private cache coherent with its peers on a shared snooping bus. It uses the five-state MOESI write-invalidate scheme over a small direct-mapped set of lines, with write-allocate and write-back. Processor reads and writes are looked up against the local line states. A hit that needs no permission change completes at once. Any other access arbitrates for the bus and broadcasts a read, a read-for-ownership or an upgrade command. Peer caches answer that command with a shared flag, a data-supply flag or a refusal.

Whenever the bus is idle, the controller answers the commands that peers broadcast. It reports whether it holds the line and whether it will source the data. It refuses a request that collides with its own outstanding memory fetch. Dirty data moves from cache to cache rather than through memory, so memory sees a writeback only when a dirty line is evicted. Four saturating counters report bus transactions, memory fetches, writebacks and cache-to-cache transfers. Data storage, bus arbitration and main memory live outside the block and are reached through request/grant and request/acknowledge handshakes.

Addresses split into a line index in the low `log2(LINES)` bits and a tag in the remaining upper bits. The bus command code is shared by the outgoing and snooped command fields: 1 = read (BusRd), 2 = read for ownership (BusRdX), 3 = upgrade (BusUpgr).

Top module: `coh_ctl`

## Requirements
- R1: After reset every line is Invalid and all four counters read zero. `cpu_ready` is high, and a snooped command gets neither the shared flag nor the supply flag.
- R2: A read miss broadcasts command 1 (read). The line fills as Exclusive when `bus_shared_in` is low during the grant cycle, and as Shared when it is high.
- R3: A read hit on any valid line, and a write hit on an Exclusive or Modified line, complete with no bus command. `cpu_done` pulses in the cycle right after the accept edge, and the line ends Modified after the write.
- R4: A write hit on a Shared or Owned line broadcasts command 3 (upgrade) and ends Modified. A write miss broadcasts command 2 (read for ownership) and ends Modified.
- R5: A snooped read that hits a Modified line raises both `snp_shared` and `snp_supply`, moves the line to Owned and causes no writeback.
- R6: A snooped read-for-ownership or upgrade that hits a valid line invalidates it. A read-for-ownership hit raises `snp_supply`, so dirty data goes to the requester. An upgrade never raises `snp_supply`.
- R7: When a peer raises `bus_supply_in` on an accepted read or read-for-ownership, the line fills from the peer. No memory fetch is issued and the cache-to-cache counter increments. With no supplier, exactly one memory fetch is issued.
- R8: Before a miss refills a line that holds a different tag in the Modified or Owned state, the old line is written back to memory at its own address. A clean victim is dropped without any memory access.
- R9: A snooped command whose address equals this cache's outstanding memory fetch is answered with `snp_nack` and leaves the line state untouched. When this cache's own command is answered with `bus_nack_in`, `bus_req` stays low for BACKOFF cycles (BACKOFF of at least 2, default 3). The command is then re-issued BACKOFF+1 cycles after the refused one.
- R10: Each counter steps by exactly one per event and holds at its all-ones value once it gets there. Counters are CNT_W bits wide, 32 by default. Every granted command counts as a bus transaction, including a refused one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_valid | input | 1 | Processor access request |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Line address of the access |
| cpu_ready | output | 1 | Access accepted on this edge when valid |
| cpu_done | output | 1 | One-cycle completion pulse |
| bus_req | output | 1 | Request for the snoop bus |
| bus_gnt | input | 1 | Bus granted |
| bus_cmd_valid | output | 1 | Command broadcast this cycle |
| bus_cmd | output | 2 | Command code (1 read, 2 read-for-ownership, 3 upgrade) |
| bus_addr | output | ADDR_W | Command line address |
| bus_shared_in | input | 1 | Some peer holds the line |
| bus_supply_in | input | 1 | Some peer sources the data |
| bus_nack_in | input | 1 | Some peer refuses the command |
| snp_valid | input | 1 | Peer command on the bus |
| snp_cmd | input | 2 | Peer command code |
| snp_addr | input | ADDR_W | Peer command line address |
| snp_shared | output | 1 | This cache holds the snooped line |
| snp_supply | output | 1 | This cache sources the data |
| snp_nack | output | 1 | Refusal: conflicting fetch outstanding |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = writeback, 0 = fetch |
| mem_addr | output | ADDR_W | Memory line address |
| mem_ack | input | 1 | Memory access complete |
| cnt_bus | output | CNT_W | Bus transaction count |
| cnt_mem | output | CNT_W | Memory fetch count |
| cnt_wb | output | CNT_W | Writeback count |
| cnt_c2c | output | CNT_W | Cache-to-cache transfer count |

## Verification
Each processor access is checked when `cpu_done` rises. For hits the bench also requires that pulse exactly one cycle after the accept edge. The state-dependent outcomes are also checked there: the fill state, the upgrade-versus-silent write, and the counter values, all settled by the edge that raised `cpu_done`. Snoop answers are combinational, so they are sampled in the same cycle as `snp_valid`, and their effect on the line shows up through the next processor access. The bus monitor samples every command on the falling edge of its grant cycle and compares it with the scoreboard entry the driver queued. It also measures the retry distance after a refusal as BACKOFF+1 cycles between command cycles.

// File: rtl/coh_pkg.sv
// Shared types of the coherence controller.
package coh_pkg;
    // Per-line coherence state.
    typedef enum logic [2:0] {
        LN_INV = 3'd0,
        LN_SHR = 3'd1,
        LN_EXC = 3'd2,
        LN_OWN = 3'd3,
        LN_MOD = 3'd4
    } line_st_t;

    // Bus command codes (shared by own and snooped commands).
    typedef enum logic [1:0] {
        CMD_NONE = 2'd0,
        CMD_RD   = 2'd1,
        CMD_RDX  = 2'd2,
        CMD_UPGR = 2'd3
    } bus_cmd_t;

    // Controller sequencing states.
    typedef enum logic [2:0] {
        CT_IDLE, CT_WB, CT_ARB, CT_BACKOFF, CT_FETCH, CT_DONE
    } ctl_st_t;
endpackage

// File: rtl/coh_sat_counter.sv
// Saturating event counter.
// Assumes: inc is a single-cycle event strobe; holds at all ones.
module coh_sat_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] q
);
    // Count events, sticking at the maximum value.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (inc && (q != {W{1'b1}}))
            q <= q + W'(1);
    end
endmodule

// File: rtl/coh_line_store.sv
// Direct-mapped state and tag store with snoop response logic.
// Assumes: the controller's own write and a snoop never target the same
// line in one cycle; if they do, the controller's write wins.
module coh_line_store
    import coh_pkg::*;
#(
    parameter int LINES = 8,
    parameter int TAG_W = 9,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] lk_idx,
    output line_st_t         lk_state,
    output logic [TAG_W-1:0] lk_tag,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  line_st_t         wr_state,
    input  logic             snp_en,
    input  bus_cmd_t         snp_cmd,
    input  logic [IDX_W-1:0] snp_idx,
    input  logic [TAG_W-1:0] snp_tag,
    output logic             snp_hit,
    output logic             snp_src
);
    line_st_t         st_q  [LINES];
    logic [TAG_W-1:0] tag_q [LINES];
    line_st_t         s_st;
    line_st_t         s_next;

    assign lk_state = st_q[lk_idx];
    assign lk_tag   = tag_q[lk_idx];

    // Snoop lookup and the state a hit line moves to.
    always_comb begin
        s_st    = st_q[snp_idx];
        snp_hit = snp_en && (s_st != LN_INV) && (tag_q[snp_idx] == snp_tag);
        snp_src = snp_hit && (snp_cmd != CMD_UPGR);
        s_next  = s_st;
        if (snp_cmd == CMD_RD) begin
            if (s_st == LN_MOD)      s_next = LN_OWN;
            else if (s_st == LN_EXC) s_next = LN_SHR;
        end else begin
            s_next = LN_INV;
        end
    end

    for (genvar i = 0; i < LINES; i++) begin : g_line
        // Hold one line: own writes first, then snoop transitions.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q[i]  <= LN_INV;
                tag_q[i] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(i))) begin
                st_q[i]  <= wr_state;
                tag_q[i] <= wr_tag;
            end else if (snp_hit && (snp_idx == IDX_W'(i))) begin
                st_q[i]  <= s_next;
            end
        end
    end
endmodule

// File: rtl/coh_ctl.sv
// MOESI per-cache coherence controller (top).
// Sequences processor accesses through writeback, bus arbitration, refusal
// backoff and memory fetch; answers peer snoops; keeps event counters.
// Assumes: snoops arrive only while this cache does not own the bus; one
// processor access is in flight at a time; LINES is a power of two >= 2.
module coh_ctl
    import coh_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int LINES   = 8,
    parameter int BACKOFF = 3,
    parameter int CNT_W   = 32,
    localparam int IDX_W  = $clog2(LINES),
    localparam int TAG_W  = ADDR_W - IDX_W,
    localparam int BO_W   = $clog2(BACKOFF + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_valid,
    input  logic              cpu_write,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic              cpu_ready,
    output logic              cpu_done,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              bus_cmd_valid,
    output logic [1:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_shared_in,
    input  logic              bus_supply_in,
    input  logic              bus_nack_in,
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_shared,
    output logic              snp_supply,
    output logic              snp_nack,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    output logic [CNT_W-1:0]  cnt_bus,
    output logic [CNT_W-1:0]  cnt_mem,
    output logic [CNT_W-1:0]  cnt_wb,
    output logic [CNT_W-1:0]  cnt_c2c
);
    localparam int K_BUS = 0, K_MEM = 1, K_WB = 2, K_C2C = 3, N_CNT = 4;

    ctl_st_t           st_q, st_d;
    logic              op_wr_q;
    logic [ADDR_W-1:0] op_addr_q;
    logic              fill_shr_q;
    logic [BO_W-1:0]   bo_q;
    logic [IDX_W-1:0]  lk_idx;
    line_st_t          lk_state;
    logic [TAG_W-1:0]  lk_tag;
    logic              wr_en;
    line_st_t          wr_state;
    logic              snp_hit, snp_src;
    logic              acc, hit_cpu, hit_op, dirty_victim;
    bus_cmd_t          cmd;
    logic [N_CNT-1:0]  cnt_inc;
    logic [CNT_W-1:0]  cnt_q [N_CNT];

    // Look up the incoming access while idle, the pending one otherwise.
    assign lk_idx       = (st_q == CT_IDLE) ? cpu_addr[IDX_W-1:0] : op_addr_q[IDX_W-1:0];
    assign hit_cpu      = (lk_state != LN_INV) && (lk_tag == cpu_addr[ADDR_W-1:IDX_W]);
    assign hit_op       = (lk_state != LN_INV) && (lk_tag == op_addr_q[ADDR_W-1:IDX_W]);
    assign dirty_victim = !hit_cpu && ((lk_state == LN_MOD) || (lk_state == LN_OWN));
    assign cpu_ready    = (st_q == CT_IDLE) && !snp_valid;
    assign acc          = cpu_ready && cpu_valid;
    assign cpu_done     = (st_q == CT_DONE);

    // Command chosen at grant time, so a line lost during backoff re-fetches.
    assign cmd           = !op_wr_q ? CMD_RD : (hit_op ? CMD_UPGR : CMD_RDX);
    assign bus_req       = (st_q == CT_ARB);
    assign bus_cmd_valid = bus_req && bus_gnt;
    assign bus_cmd       = bus_cmd_valid ? cmd : CMD_NONE;
    assign bus_addr      = op_addr_q;

    assign mem_req  = (st_q == CT_WB) || (st_q == CT_FETCH);
    assign mem_we   = (st_q == CT_WB);
    assign mem_addr = (st_q == CT_WB) ? {lk_tag, op_addr_q[IDX_W-1:0]} : op_addr_q;

    assign snp_nack   = snp_valid && (st_q == CT_FETCH) && (snp_addr == op_addr_q);
    assign snp_shared = snp_hit;
    assign snp_supply = snp_src;

    // Next sequencing state, line writes and counter strobes.
    always_comb begin
        st_d     = st_q;
        wr_en    = 1'b0;
        wr_state = LN_INV;
        cnt_inc  = '0;
        unique case (st_q)
            CT_IDLE: if (acc) begin
                if (hit_cpu && !cpu_write) begin
                    st_d = CT_DONE;
                end else if (hit_cpu && ((lk_state == LN_EXC) || (lk_state == LN_MOD))) begin
                    wr_en = 1'b1; wr_state = LN_MOD; st_d = CT_DONE;
                end else if (dirty_victim) begin
                    st_d = CT_WB; cnt_inc[K_WB] = 1'b1;
                end else begin
                    st_d = CT_ARB;
                end
            end
            CT_WB: if (mem_ack) begin
                wr_en = 1'b1; wr_state = LN_INV; st_d = CT_ARB;
            end
            CT_ARB: if (bus_gnt) begin
                cnt_inc[K_BUS] = 1'b1;
                if (bus_nack_in) begin
                    st_d = CT_BACKOFF;
                end else if (cmd == CMD_UPGR) begin
                    wr_en = 1'b1; wr_state = LN_MOD; st_d = CT_DONE;
                end else if (bus_supply_in) begin
                    cnt_inc[K_C2C] = 1'b1; wr_en = 1'b1; st_d = CT_DONE;
                    wr_state = op_wr_q ? LN_MOD : (bus_shared_in ? LN_SHR : LN_EXC);
                end else begin
                    cnt_inc[K_MEM] = 1'b1; wr_en = 1'b1; wr_state = LN_INV; st_d = CT_FETCH;
                end
            end
            CT_BACKOFF: if (bo_q == '0) st_d = CT_ARB;
            CT_FETCH: if (mem_ack) begin
                wr_en = 1'b1; st_d = CT_DONE;
                wr_state = op_wr_q ? LN_MOD : (fill_shr_q ? LN_SHR : LN_EXC);
            end
            CT_DONE: st_d = CT_IDLE;
            default: st_d = CT_IDLE;
        endcase
    end

    // Sequencer registers and the captured access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= CT_IDLE;
            op_wr_q    <= 1'b0;
            op_addr_q  <= '0;
            fill_shr_q <= 1'b0;
            bo_q       <= '0;
        end else begin
            st_q <= st_d;
            if (acc) begin
                op_wr_q   <= cpu_write;
                op_addr_q <= cpu_addr;
            end
            if (bus_cmd_valid) fill_shr_q <= bus_shared_in;
            if (bus_cmd_valid && bus_nack_in) bo_q <= BO_W'(BACKOFF - 1);
            else if (st_q == CT_BACKOFF)      bo_q <= bo_q - BO_W'(1);
        end
    end

    coh_line_store #(.LINES(LINES), .TAG_W(TAG_W)) store_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_idx   (lk_idx),
        .lk_state (lk_state),
        .lk_tag   (lk_tag),
        .wr_en    (wr_en),
        .wr_idx   (op_addr_q[IDX_W-1:0] & {IDX_W{st_q != CT_IDLE}} | cpu_addr[IDX_W-1:0] & {IDX_W{st_q == CT_IDLE}}),
        .wr_tag   ((st_q == CT_IDLE) ? cpu_addr[ADDR_W-1:IDX_W] : op_addr_q[ADDR_W-1:IDX_W]),
        .wr_state (wr_state),
        .snp_en   (snp_valid && !snp_nack),
        .snp_cmd  (bus_cmd_t'(snp_cmd)),
        .snp_idx  (snp_addr[IDX_W-1:0]),
        .snp_tag  (snp_addr[ADDR_W-1:IDX_W]),
        .snp_hit  (snp_hit),
        .snp_src  (snp_src)
    );

    for (genvar k = 0; k < N_CNT; k++) begin : g_cnt
        coh_sat_counter #(.W(CNT_W)) cnt_i (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (cnt_inc[k]),
            .q     (cnt_q[k])
        );
    end

    assign cnt_bus = cnt_q[K_BUS];
    assign cnt_mem = cnt_q[K_MEM];
    assign cnt_wb  = cnt_q[K_WB];
    assign cnt_c2c = cnt_q[K_C2C];
endmodule

// File: rtl/coh_ctl_chk.sv
// Protocol checker for coh_ctl, attached by bind.
// Assumes: BACKOFF of at least 2 in the bound instance.
module coh_ctl_chk #(
    parameter int ADDR_W = 12,
    parameter int CNT_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_done,
    input logic              bus_req,
    input logic              bus_cmd_valid,
    input logic              bus_nack_in,
    input logic              bus_supply_in,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              snp_valid,
    input logic [1:0]        snp_cmd,
    input logic [ADDR_W-1:0] snp_addr,
    input logic              snp_nack,
    input logic              snp_supply,
    input logic [CNT_W-1:0]  cnt_bus
);
    // R3: completion is a single-cycle pulse.
    p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |=> !cpu_done);

    // R6: an upgrade never pulls data out of this cache.
    p_upgr_no_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && snp_cmd == 2'd3) |-> !snp_supply);

    // R7: a peer-supplied fill never goes to memory next.
    p_c2c_no_fetch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd_valid && bus_supply_in && !bus_nack_in) |=> !mem_req);

    // R8: writebacks happen before arbitration, never alongside it.
    p_wb_apart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> !bus_req);

    // R9: refusals only for the address being fetched.
    p_nack_fetch_r9: assert property (@(posedge clk) disable iff (!rst_n)
        snp_nack |-> (mem_req && !mem_we && mem_addr == snp_addr));

    // R9: at least two quiet cycles after our own command is refused.
    p_backoff_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd_valid && bus_nack_in) |=> !bus_req ##1 !bus_req);

    // R10: the bus counter only ever steps by one.
    p_cnt_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_bus != $past(cnt_bus)) |-> (cnt_bus == $past(cnt_bus) + CNT_W'(1)));
endmodule

bind coh_ctl coh_ctl_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) chk_i (.*);

// File: tb/coh_ctl_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: op driver queues expected bus commands, a monitor pops them.
module coh_ctl_tb_top;
    localparam int AW = 12;
    localparam int BO = 3;
    localparam int CW = 4;
    localparam int CMAX = (1 << CW) - 1;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cpu_valid = 1'b0, cpu_write = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic cpu_ready, cpu_done, bus_req, bus_gnt, bus_cmd_valid;
    logic [1:0] bus_cmd;
    logic [AW-1:0] bus_addr, mem_addr;
    logic bus_shared_in = 1'b0, bus_supply_in = 1'b0, bus_nack_in;
    logic snp_valid = 1'b0;
    logic [1:0] snp_cmd = '0;
    logic [AW-1:0] snp_addr = '0;
    logic snp_shared, snp_supply, snp_nack, mem_req, mem_we, mem_ack;
    logic [CW-1:0] cnt_bus, cnt_mem, cnt_wb, cnt_c2c;

    int n_chk = 0, n_fail = 0, cyc = 0;
    int nack_left = 0, mem_delay = 2, mem_cnt = 0;
    int wb_seen = 0, fetch_seen = 0, last_cmd_cyc = 0, last_gap = 0;
    logic [AW-1:0] last_wb_addr = '0;
    logic [AW+1:0] exp_q [$];
    int e_bus = 0, e_mem = 0, e_wb = 0, e_c2c = 0;
    int lat;

    always #2.5 clk = ~clk;

    coh_ctl #(.ADDR_W(AW), .LINES(8), .BACKOFF(BO), .CNT_W(CW)) dut_i (.*);

    assign bus_gnt     = bus_req;
    assign bus_nack_in = (nack_left != 0);
    assign mem_ack     = mem_req && (mem_cnt == mem_delay);

    // Peer and memory models plus event bookkeeping.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        mem_cnt <= (mem_req && !mem_ack) ? mem_cnt + 1 : 0;
        if (bus_cmd_valid && nack_left != 0) nack_left <= nack_left - 1;
        if (mem_req && mem_ack && mem_we) begin
            wb_seen <= wb_seen + 1;
            last_wb_addr <= mem_addr;
        end
        if (mem_req && mem_ack && !mem_we) fetch_seen <= fetch_seen + 1;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: every broadcast command must match the scoreboard head.
    always @(negedge clk) begin
        if (rst_n && bus_cmd_valid) begin
            last_gap = cyc - last_cmd_cyc;
            last_cmd_cyc = cyc;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R3 unexpected bus command", {bus_cmd, bus_addr}, 0);
            end else begin
                logic [AW+1:0] e;
                e = exp_q.pop_front();
                chk({bus_cmd, bus_addr} == e, "R2/R4 bus command", {bus_cmd, bus_addr}, e);
            end
        end
    end

    function automatic int sat(input int v);
        return (v > CMAX) ? CMAX : v;
    endfunction

    task automatic expect_cmd(input logic [1:0] c, input logic [AW-1:0] a);
        exp_q.push_back({c, a});
    endtask

    task automatic cnt_check(input string req);
        chk(cnt_bus == sat(e_bus), {req, " bus count"}, cnt_bus, sat(e_bus));
        chk(cnt_mem == sat(e_mem), {req, " mem count"}, cnt_mem, sat(e_mem));
        chk(cnt_wb  == sat(e_wb),  {req, " wb count"},  cnt_wb,  sat(e_wb));
        chk(cnt_c2c == sat(e_c2c), {req, " c2c count"}, cnt_c2c, sat(e_c2c));
    endtask

    // Driver: one processor access; returns cycles from accept to done.
    task automatic op(input bit w, input logic [AW-1:0] a, input bit sh, input bit sup,
                      input int nk, output int l);
        @(negedge clk);
        bus_shared_in = sh; bus_supply_in = sup; nack_left = nk;
        cpu_valid = 1'b1; cpu_write = w; cpu_addr = a;
        while (!cpu_ready) @(negedge clk);
        @(negedge clk);
        cpu_valid = 1'b0;
        l = 1;
        while (!cpu_done && l < 100) begin
            @(negedge clk);
            l++;
        end
        bus_shared_in = 1'b0; bus_supply_in = 1'b0;
    endtask

    task automatic snoop(input logic [1:0] c, input logic [AW-1:0] a, input bit esh,
                         input bit esup, input bit enk, input string req);
        @(negedge clk);
        snp_valid = 1'b1; snp_cmd = c; snp_addr = a;
        #1;
        chk(snp_shared == esh, {req, " snp_shared"}, snp_shared, esh);
        chk(snp_supply == esup, {req, " snp_supply"}, snp_supply, esup);
        chk(snp_nack == enk, {req, " snp_nack"}, snp_nack, enk);
        @(negedge clk);
        snp_valid = 1'b0;
    endtask

    task automatic report;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        report();
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(cpu_ready == 1'b1, "R1 cpu_ready", cpu_ready, 1);
        cnt_check("R1");
        snoop(2'd1, 12'h010, 0, 0, 0, "R1 empty lines");

        // R2: read miss, no sharer -> Exclusive; R7 memory fetch
        expect_cmd(2'd1, 12'h010); e_bus++; e_mem++;
        op(0, 12'h010, 0, 0, 0, lat);
        cnt_check("R2 R7");
        // R3: write hit on Exclusive is silent, read hit silent
        op(1, 12'h010, 0, 0, 0, lat);
        chk(lat == 1, "R3 write hit latency", lat, 1);
        op(0, 12'h010, 0, 0, 0, lat);
        chk(lat == 1, "R3 read hit latency", lat, 1);
        cnt_check("R3");

        // R2: read miss with sharer -> Shared; R4 write hit on Shared upgrades
        expect_cmd(2'd1, 12'h021); e_bus++; e_mem++;
        op(0, 12'h021, 1, 0, 0, lat);
        expect_cmd(2'd3, 12'h021); e_bus++;
        op(1, 12'h021, 0, 0, 0, lat);
        cnt_check("R2 R4");

        // R5: snooped read on Modified supplies, goes Owned (write then upgrades)
        snoop(2'd1, 12'h021, 1, 1, 0, "R5");
        expect_cmd(2'd3, 12'h021); e_bus++;
        op(1, 12'h021, 0, 0, 0, lat);
        cnt_check("R5 no writeback");

        // R6: snooped read-for-ownership on Modified supplies and invalidates
        snoop(2'd2, 12'h010, 1, 1, 0, "R6 rdx");
        expect_cmd(2'd1, 12'h010); e_bus++; e_c2c++;
        op(0, 12'h010, 1, 1, 0, lat);
        cnt_check("R6 R7 peer fill");
        chk(fetch_seen == 2, "R7 no memory fetch on peer fill", fetch_seen, 2);

        // R6: snooped upgrade invalidates without supplying
        snoop(2'd3, 12'h010, 1, 0, 0, "R6 upgr");
        expect_cmd(2'd1, 12'h010); e_bus++; e_mem++;
        op(0, 12'h010, 0, 0, 0, lat);
        op(1, 12'h010, 0, 0, 0, lat);
        chk(lat == 1, "R2 refill Exclusive silent write", lat, 1);
        cnt_check("R6 refetch");

        // R4 write miss + R8 dirty victim writeback
        expect_cmd(2'd2, 12'h031); e_bus++; e_mem++; e_wb++;
        op(1, 12'h031, 0, 0, 0, lat);
        chk(last_wb_addr == 12'h021, "R8 writeback address", last_wb_addr, 12'h021);
        op(1, 12'h031, 0, 0, 0, lat);
        chk(lat == 1, "R4 write miss ends Modified", lat, 1);
        expect_cmd(2'd1, 12'h041); e_bus++; e_mem++; e_wb++;
        op(0, 12'h041, 0, 0, 0, lat);
        chk(last_wb_addr == 12'h031, "R8 writeback address 2", last_wb_addr, 12'h031);
        expect_cmd(2'd1, 12'h051); e_bus++; e_mem++;
        op(0, 12'h051, 0, 0, 0, lat);
        chk(wb_seen == 2, "R8 clean victim dropped", wb_seen, 2);
        cnt_check("R8");

        // R9: own command refused -> backoff then retry
        expect_cmd(2'd1, 12'h012); expect_cmd(2'd1, 12'h012);
        e_bus += 2; e_mem++;
        op(0, 12'h012, 0, 0, 1, lat);
        chk(last_gap == BO + 1, "R9 retry distance", last_gap, BO + 1);
        cnt_check("R9 retry");

        // R9: snoop on outstanding fetch is refused; other address is not
        mem_delay = 8;
        expect_cmd(2'd1, 12'h013); e_bus++; e_mem++;
        fork
            op(0, 12'h013, 0, 0, 0, lat);
            begin
                do @(negedge clk); while (!(mem_req && !mem_we));
                snoop(2'd2, 12'h013, 0, 0, 1, "R9 refuse");
                snoop(2'd1, 12'h023, 0, 0, 0, "R9 other address");
            end
        join
        mem_delay = 2;
        op(1, 12'h013, 0, 0, 0, lat);
        chk(lat == 1, "R9 refused snoop left line Exclusive", lat, 1);
        cnt_check("R9 refuse");

        // R10: bus counter saturates at all ones while others keep counting
        for (int i = 4; i < 9; i++) begin
            logic [AW-1:0] a;
            a = AW'(12'h010 + i);
            if (i == 8) e_wb++;
            expect_cmd(2'd1, a); e_bus++; e_mem++;
            op(0, a, 0, 0, 0, lat);
        end
        chk(cnt_bus == CW'(CMAX), "R10 saturation", cnt_bus, CMAX);
        cnt_check("R10");
        chk(exp_q.size() == 0, "R2 all commands seen", exp_q.size(), 0);

        report();
        $finish;
    end
endmodule